// File: doc/BRIEF.md
# Radar Chirp Scan Sequencer

This block paces a radar transmit/receive schedule. Each chirp passes through five timed phases: long chirp, long listen, guard, short chirp and short listen. A one-cycle advance step follows, in which the chirp, elevation and azimuth counters move forward as nested counters. The length of each phase, in clock cycles, and the number of chirps per elevation come in as configuration inputs. The number of elevations per azimuth and the number of azimuths per scan are design parameters.

Events are reported as level toggles on three indicator outputs. The elevation and azimuth counts are also output, together with a scanning flag and a one-cycle scan-done pulse. In manual mode a trigger pulse runs exactly one scan. In automatic mode scans follow each other with no gap.

The block also drives a commit strobe. A surrounding register stage can use it to copy a staged set of timing values into the set that drives this sequencer. The strobe is high for as long as the block is idle. During a scan it pulses only in the advance cycle that closes an elevation, so a new set always starts at a frame boundary. The strobe is a combinational decode of registered state and adds no flip-flop.

Top module: `chirp_scan_seq`

## Requirements
- R1: While reset is asserted, the toggles, both counts, `scanning` and `scanDone` are 0, and `commitStrobe` is 1.
- R2: Each chirp runs the phases long chirp, long listen, guard, short chirp, short listen, then one advance cycle. A phase configured to d lasts d cycles, and d = 0 lasts 1 cycle. `chirpToggle` inverts on the clock edge that starts each chirp.
- R3: `commitStrobe` is 1 in every cycle in which `scanning` is 0.
- R4: While scanning, `commitStrobe` is 1 only in the advance cycle of a chirp whose index plus one is at least `cfgChirpsPerElev`. A value of 0 acts like 1.
- R5: At that elevation boundary the chirp index returns to 0 and `elevToggle` inverts. `elevCount` increments, or wraps to 0 after ELEVS-1. It changes at no other time.
- R6: When `elevCount` wraps, `azimToggle` inverts and `azimCount` increments, or wraps to 0 after AZIMS-1. It changes at no other time.
- R7: `scanDone` is high for exactly one cycle: the cycle after the advance of the last chirp of the last elevation of the last azimuth. Both counts read 0 in that cycle.
- R8: With `autoMode` high, `scanning` is 1 from the first clock edge after reset is released, and `commitStrobe` is 0 at that point. A new scan follows scan completion with `scanning` staying 1.
- R9: With `autoMode` low, a `trigger` seen while idle starts one full scan, after which the block returns to idle. A `trigger` during a scan has no effect.
- R10: Each phase duration is sampled when the phase is entered. A change to a configuration input during a phase does not alter the length of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| autoMode | input | 1 | 1 = continuous scans, 0 = one scan per trigger |
| trigger | input | 1 | Starts a scan when idle (manual mode) |
| cfgLongChirp | input | TIMER_W | Long chirp duration in cycles |
| cfgLongListen | input | TIMER_W | Long listen duration in cycles |
| cfgGuard | input | TIMER_W | Guard duration in cycles |
| cfgShortChirp | input | TIMER_W | Short chirp duration in cycles |
| cfgShortListen | input | TIMER_W | Short listen duration in cycles |
| cfgChirpsPerElev | input | CNT_W | Chirps per elevation |
| chirpToggle | output | 1 | Inverts at each chirp start |
| elevToggle | output | 1 | Inverts at each elevation boundary |
| azimToggle | output | 1 | Inverts at each azimuth boundary |
| elevCount | output | CNT_W | Current elevation index |
| azimCount | output | CNT_W | Current azimuth index |
| scanning | output | 1 | 1 while a scan is in progress |
| scanDone | output | 1 | One-cycle pulse after a full scan |
| commitStrobe | output | 1 | Safe window for swapping timing values |

## Verification
A behavioural model tracks the remaining phase cycles and the nested indices, and the outputs are compared with it on every clock. The main function is tried with four patterns:
- Unequal nonzero durations with three chirps per elevation. This separates the phase order and length from the chirp-index boundary.
- All-zero durations with one chirp per elevation, then with zero chirps per elevation. These expose any mishandling of the zero-length clamp and of the boundary decode.
- Changes to the durations in the middle of a phase. These tell whether durations are sampled at phase entry or read continuously.
- A trigger in the middle of a scan and an automatic-mode run over several scans. These separate idle re-arming from back-to-back restart.

// File: rtl/chirp_scan_pkg.sv
package chirp_scan_pkg;

  localparam int NUM_PHASES = 5;
  localparam int PH_W       = 3;

  // Values 1..5 are the timed phases in order; the phase index is value-1.
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LCHIRP  = 3'd1,
    ST_LLISTEN = 3'd2,
    ST_GUARD   = 3'd3,
    ST_SCHIRP  = 3'd4,
    ST_SLISTEN = 3'd5,
    ST_ADVANCE = 3'd6
  } seq_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic            load;       // reload the phase timer
    logic [PH_W-1:0] loadPhase;  // which duration to reload from
    logic            dec;        // count the timer down
    logic            chirpStart; // a chirp begins on this edge
    logic            step;       // advance the nested counters
  } ctrl_strobe_t;

endpackage

// File: rtl/chirp_scan_dp.sv
module chirp_scan_dp
  import chirp_scan_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 6,
  parameter int ELEVS   = 31,
  parameter int AZIMS   = 50
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ctrl_strobe_t                         strb,
  input  logic [NUM_PHASES-1:0][TIMER_W-1:0]   durs,
  input  logic [CNT_W-1:0]                     chirpsPerElev,
  output logic                                 timerLast,
  output logic                                 lastChirp,
  output logic                                 lastAll,
  output logic                                 chirpToggle,
  output logic                                 elevToggle,
  output logic                                 azimToggle,
  output logic [CNT_W-1:0]                     elevCount,
  output logic [CNT_W-1:0]                     azimCount,
  output logic                                 scanDone
);

  localparam logic [CNT_W-1:0] ELEV_LAST = CNT_W'(ELEVS - 1);
  localparam logic [CNT_W-1:0] AZIM_LAST = CNT_W'(AZIMS - 1);

  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] loadVal;
  logic [CNT_W-1:0]   chirpCnt;
  logic               lastElev;
  logic               lastAzim;

  // Duration select for the phase being entered
  always_comb begin
    loadVal = '0;
    for (int i = 0; i < NUM_PHASES; i++) begin
      if (strb.loadPhase == PH_W'(i)) loadVal = durs[i];
    end
  end

  // Down-counting phase timer; a value of 0 or 1 ends the phase this cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          timer <= '0;
    else if (strb.load) timer <= loadVal;
    else if (strb.dec)  timer <= timer - 1'b1;
  end

  assign timerLast = (timer <= TIMER_W'(1));

  // Boundary decodes; chirps-per-elevation of 0 behaves as 1
  assign lastChirp = ({1'b0, chirpCnt} + 1'b1) >= {1'b0, chirpsPerElev};
  assign lastElev  = (elevCount >= ELEV_LAST);
  assign lastAzim  = (azimCount >= AZIM_LAST);
  assign lastAll   = lastChirp && lastElev && lastAzim;

  // Nested counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chirpCnt   <= '0;
      elevCount  <= '0;
      azimCount  <= '0;
      elevToggle <= 1'b0;
      azimToggle <= 1'b0;
    end else if (strb.step) begin
      if (lastChirp) begin
        chirpCnt   <= '0;
        elevToggle <= ~elevToggle;
        if (lastElev) begin
          elevCount  <= '0;
          azimToggle <= ~azimToggle;
          if (lastAzim) azimCount <= '0;
          else          azimCount <= azimCount + 1'b1;
        end else begin
          elevCount <= elevCount + 1'b1;
        end
      end else begin
        chirpCnt <= chirpCnt + 1'b1;
      end
    end
  end

  // Chirp indicator and scan completion pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chirpToggle <= 1'b0;
      scanDone    <= 1'b0;
    end else begin
      if (strb.chirpStart) chirpToggle <= ~chirpToggle;
      scanDone <= strb.step && lastAll;
    end
  end

endmodule

// File: rtl/chirp_scan_ctrl.sv
module chirp_scan_ctrl
  import chirp_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         autoMode,
  input  logic         trigger,
  input  logic         timerLast,
  input  logic         lastChirp,
  input  logic         lastAll,
  output ctrl_strobe_t strb,
  output logic         scanning,
  output logic         commitStrobe
);

  seq_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (autoMode || trigger) begin
          nextState       = ST_LCHIRP;
          strb.load       = 1'b1;
          strb.loadPhase  = PH_W'(0);
          strb.chirpStart = 1'b1;
        end
      end
      ST_ADVANCE: begin
        strb.step = 1'b1;
        if (lastAll && !autoMode) begin
          nextState = ST_IDLE;
        end else begin
          nextState       = ST_LCHIRP;
          strb.load       = 1'b1;
          strb.loadPhase  = PH_W'(0);
          strb.chirpStart = 1'b1;
        end
      end
      default: begin
        if (timerLast) begin
          if (state == ST_SLISTEN) begin
            nextState = ST_ADVANCE;
          end else begin
            nextState      = seq_state_e'(state + 3'd1);
            strb.load      = 1'b1;
            strb.loadPhase = PH_W'(state);  // next phase index
          end
        end else begin
          strb.dec = 1'b1;
        end
      end
    endcase
  end

  assign scanning     = (state != ST_IDLE);
  assign commitStrobe = (state == ST_IDLE) || ((state == ST_ADVANCE) && lastChirp);

endmodule

// File: rtl/chirp_scan_seq.sv
module chirp_scan_seq
  import chirp_scan_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 6,
  parameter int ELEVS   = 31,
  parameter int AZIMS   = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               autoMode,
  input  logic               trigger,
  input  logic [TIMER_W-1:0] cfgLongChirp,
  input  logic [TIMER_W-1:0] cfgLongListen,
  input  logic [TIMER_W-1:0] cfgGuard,
  input  logic [TIMER_W-1:0] cfgShortChirp,
  input  logic [TIMER_W-1:0] cfgShortListen,
  input  logic [CNT_W-1:0]   cfgChirpsPerElev,
  output logic               chirpToggle,
  output logic               elevToggle,
  output logic               azimToggle,
  output logic [CNT_W-1:0]   elevCount,
  output logic [CNT_W-1:0]   azimCount,
  output logic               scanning,
  output logic               scanDone,
  output logic               commitStrobe
);

  ctrl_strobe_t                       strb;
  logic [NUM_PHASES-1:0][TIMER_W-1:0] durs;
  logic                               timerLast;
  logic                               lastChirp;
  logic                               lastAll;

  // Phase order follows the index used by the control
  assign durs[0] = cfgLongChirp;
  assign durs[1] = cfgLongListen;
  assign durs[2] = cfgGuard;
  assign durs[3] = cfgShortChirp;
  assign durs[4] = cfgShortListen;

  chirp_scan_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .autoMode     (autoMode),
    .trigger      (trigger),
    .timerLast    (timerLast),
    .lastChirp    (lastChirp),
    .lastAll      (lastAll),
    .strb         (strb),
    .scanning     (scanning),
    .commitStrobe (commitStrobe)
  );

  chirp_scan_dp #(
    .TIMER_W (TIMER_W),
    .CNT_W   (CNT_W),
    .ELEVS   (ELEVS),
    .AZIMS   (AZIMS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .durs          (durs),
    .chirpsPerElev (cfgChirpsPerElev),
    .timerLast     (timerLast),
    .lastChirp     (lastChirp),
    .lastAll       (lastAll),
    .chirpToggle   (chirpToggle),
    .elevToggle    (elevToggle),
    .azimToggle    (azimToggle),
    .elevCount     (elevCount),
    .azimCount     (azimCount),
    .scanDone      (scanDone)
  );

endmodule

// File: rtl/chirp_scan_chk.sv
module chirp_scan_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             chirpToggle,
  input logic             elevToggle,
  input logic             azimToggle,
  input logic [CNT_W-1:0] elevCount,
  input logic [CNT_W-1:0] azimCount,
  input logic             scanning,
  input logic             scanDone,
  input logic             commitStrobe
);

  AST_IDLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !scanning |-> commitStrobe);  // R3

  AST_ELEV_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (elevToggle != $past(elevToggle)) |-> $past(commitStrobe && scanning));  // R4

  AST_ELEV_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (elevToggle == $past(elevToggle)) |-> $stable(elevCount));  // R5

  AST_AZIM_WITH_ELEV: assert property (@(posedge clk) disable iff (!rstN)
    (azimToggle != $past(azimToggle)) |-> (elevToggle != $past(elevToggle)));  // R6

  AST_AZIM_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (azimToggle == $past(azimToggle)) |-> $stable(azimCount));  // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);  // R7

  AST_DONE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (elevCount == '0 && azimCount == '0));  // R7

  AST_IDLE_NO_CHIRP: assert property (@(posedge clk) disable iff (!rstN)
    (!scanning && !$past(scanning)) |-> $stable(chirpToggle));  // R9

endmodule

bind chirp_scan_seq chirp_scan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_chirp_scan_seq.sv
module sim_chirp_scan_seq;

  localparam int TW = 16;
  localparam int CW = 6;
  localparam int NE = 2;
  localparam int NA = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rstN = 1'b0;
  logic          autoMode = 1'b0;
  logic          trigger = 1'b0;
  logic [TW-1:0] dLC = 16'd3, dLL = 16'd2, dGD = 16'd2, dSC = 16'd1, dSL = 16'd2;
  logic [CW-1:0] cpe = 6'd3;

  logic          chirpToggle, elevToggle, azimToggle;
  logic [CW-1:0] elevCount, azimCount;
  logic          scanning, scanDone, commitStrobe;

  chirp_scan_seq #(.TIMER_W(TW), .CNT_W(CW), .ELEVS(NE), .AZIMS(NA)) u0 (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .trigger(trigger),
    .cfgLongChirp(dLC), .cfgLongListen(dLL), .cfgGuard(dGD),
    .cfgShortChirp(dSC), .cfgShortListen(dSL), .cfgChirpsPerElev(cpe),
    .chirpToggle(chirpToggle), .elevToggle(elevToggle), .azimToggle(azimToggle),
    .elevCount(elevCount), .azimCount(azimCount), .scanning(scanning),
    .scanDone(scanDone), .commitStrobe(commitStrobe)
  );

  int nCompared = 0;
  int nFailed   = 0;
  bit finished  = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nCompared++;
    if (!ok) begin
      nFailed++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  // mSt: -1 idle, 0..4 timed phases, 5 advance
  int mSt = -1, mRem = 0, mChirp = 0, mElev = 0, mAzim = 0;
  int mCT = 0, mET = 0, mAT = 0, mDone = 0;

  function automatic int durOf(int p);
    int d;
    case (p)
      0: d = int'(dLC);
      1: d = int'(dLL);
      2: d = int'(dGD);
      3: d = int'(dSC);
      default: d = int'(dSL);
    endcase
    return (d == 0) ? 1 : d;
  endfunction

  task automatic enterPhase(int p);
    mSt  = p;
    mRem = durOf(p);  // R10: length fixed at entry
    if (p == 0) mCT = 1 - mCT;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = -1; mRem = 0; mChirp = 0; mElev = 0; mAzim = 0;
      mCT = 0; mET = 0; mAT = 0; mDone = 0;
    end else begin
      mDone = 0;
      if (mSt == -1) begin
        if (autoMode || trigger) enterPhase(0);
      end else if (mSt == 5) begin
        if (mChirp + 1 >= int'(cpe)) begin
          mChirp = 0;
          mET = 1 - mET;
          if (mElev + 1 >= NE) begin
            mElev = 0;
            mAT = 1 - mAT;
            if (mAzim + 1 >= NA) begin
              mAzim = 0;
              mDone = 1;
            end else mAzim++;
          end else mElev++;
        end else mChirp++;
        if (mDone == 1 && !autoMode) mSt = -1;
        else enterPhase(0);
      end else begin
        mRem--;
        if (mRem == 0) begin
          if (mSt < 4) enterPhase(mSt + 1);
          else mSt = 5;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int   nDone = 0, nCommit = 0, nChirp = 0;
  logic prevCT = 1'b0;

  always @(posedge clk) begin
    #3;
    if (!rstN) begin
      prevCT = 1'b0;
    end else if (!finished) begin
      int expCommit;
      expCommit = (mSt == -1 || (mSt == 5 && mChirp + 1 >= int'(cpe))) ? 1 : 0;
      check(int'(chirpToggle) == mCT, "R2", "chirpToggle", int'(chirpToggle), mCT);
      check(int'(elevToggle) == mET, "R5", "elevToggle", int'(elevToggle), mET);
      check(int'(elevCount) == mElev, "R5", "elevCount", int'(elevCount), mElev);
      check(int'(azimToggle) == mAT, "R6", "azimToggle", int'(azimToggle), mAT);
      check(int'(azimCount) == mAzim, "R6", "azimCount", int'(azimCount), mAzim);
      check(int'(scanning) == ((mSt != -1) ? 1 : 0), "R9", "scanning", int'(scanning), (mSt != -1) ? 1 : 0);
      check(int'(scanDone) == mDone, "R7", "scanDone", int'(scanDone), mDone);
      check(int'(commitStrobe) == expCommit, "R4", "commitStrobe", int'(commitStrobe), expCommit);
      if (scanDone) nDone++;
      if (commitStrobe && scanning) nCommit++;
      if (chirpToggle !== prevCT) nChirp++;
      prevCT = chirpToggle;
    end
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      nCompared++;
      nFailed++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic clearTallies();
    nDone = 0; nCommit = 0; nChirp = 0;
  endtask

  task automatic pulseTrigger();
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic waitIdle(string req);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!scanning) break;
    end
    check(scanning == 1'b0, req, "returned to idle", int'(scanning), 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(chirpToggle == 1'b0 && elevToggle == 1'b0 && azimToggle == 1'b0, "R1", "toggles",
          int'({chirpToggle, elevToggle, azimToggle}), 0);
    check(elevCount == '0 && azimCount == '0, "R1", "counts", int'(elevCount) + int'(azimCount), 0);
    check(scanning == 1'b0 && scanDone == 1'b0, "R1", "scanning/scanDone", int'({scanning, scanDone}), 0);
    check(commitStrobe == 1'b1, "R1", "commitStrobe", int'(commitStrobe), 1);

    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R3: idle commit window, R9: no self start in manual mode
    check(commitStrobe == 1'b1, "R3", "idle commitStrobe", int'(commitStrobe), 1);
    check(scanning == 1'b0, "R9", "idle without trigger", int'(scanning), 0);

    // Manual scan, unequal durations, trigger during scan, mid-phase change
    clearTallies();
    pulseTrigger();
    repeat (40) @(negedge clk);
    pulseTrigger();              // R9: must be ignored
    repeat (31) @(negedge clk);
    dLC = 16'd5; dGD = 16'd1;    // R10: change while a phase runs
    repeat (7) @(negedge clk);
    dLL = 16'd4;
    waitIdle("R9");
    check(nDone == 1, "R7", "scanDone pulses in one scan", nDone, 1);
    check(nCommit == NE * NA, "R4", "commit pulses per scan", nCommit, NE * NA);
    check(nChirp == 3 * NE * NA, "R2", "chirps per scan", nChirp, 3 * NE * NA);

    // Zero durations, one chirp per elevation
    dLC = 0; dLL = 0; dGD = 0; dSC = 0; dSL = 0; cpe = 6'd1;
    clearTallies();
    pulseTrigger();
    waitIdle("R9");
    check(nChirp == NE * NA, "R2", "chirps with cpe 1", nChirp, NE * NA);
    check(nCommit == NE * NA, "R4", "commit pulses with cpe 1", nCommit, NE * NA);

    // Zero chirps per elevation behaves as one
    cpe = 6'd0;
    clearTallies();
    pulseTrigger();
    waitIdle("R9");
    check(nChirp == NE * NA, "R4", "chirps with cpe 0", nChirp, NE * NA);
    check(nDone == 1, "R7", "scanDone with cpe 0", nDone, 1);

    // Automatic mode
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    dLC = 16'd2; dLL = 16'd1; dGD = 16'd3; dSC = 16'd1; dSL = 16'd1; cpe = 6'd2;
    autoMode = 1'b1;
    clearTallies();
    rstN = 1'b1;
    @(posedge clk);
    #3;
    check(scanning == 1'b1, "R8", "scanning after first edge", int'(scanning), 1);
    check(commitStrobe == 1'b0, "R8", "commitStrobe after start", int'(commitStrobe), 0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (nDone >= 2) break;
    end
    check(nDone == 2, "R8", "back-to-back scans", nDone, 2);
    check(scanning == 1'b1, "R8", "scanning across restart", int'(scanning), 1);
    autoMode = 1'b0;
    waitIdle("R9");
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule